// File: doc/BRIEF.md
# Lazy Condition Code Evaluator

The block turns a recorded operation into condition flags. It does not watch an adder. Instead it receives a description of the last flag-setting operation: its class, its operand size (byte, halfword or word) and three 32-bit values (source, destination and result). From these it derives negative, zero, overflow and carry. Multiplies also receive the upper word of the 64-bit product. A bit-test class uses its own rule. The derived flags are folded into the previous status word under a software-supplied update mask. The result is registered and returned as the new status word.

A CPU pipeline uses the block when it defers flag computation until a consumer needs the flags. The pipeline keeps the recorded operands and then presents them for one cycle with `valid_i`. The merged status word appears on `status_o` on the next clock edge and is held there until the next strobe.

Carry is not taken from an adder. It is estimated from the sign bits of the operands and of the result. Subtraction and compare invert the source before the estimate and invert the final carry. In extended-arithmetic mode the zero flag can be cleared but never set.

Top module: `lazy_flag_unit`

## Requirements
- R1: `status_o` and `valid_o` reset to 0. One clock edge after `valid_i` is high, `valid_o` is 1 and `status_o` holds the new status. When `valid_i` is low, `valid_o` is 0 on the next edge and `status_o` keeps its value.
- R2: Status bit positions are C=0, V=1, Z=2, N=3, X=4 and R=8. Size codes are 0 for byte (sign bit 7), 1 for halfword (sign bit 15), and 2 or 3 for word (sign bit 31). Op codes 0 and 15 are add class. For the add class, if the result sign bit at the size is 1, the new N is 1, V is 1 when both operand sign bits are 0, C is 1 when both are 1, and Z is 0.
- R3: For the add class with a result sign bit of 0, N is 0. Z is 1 when the result masked to the size is zero. V is 1 when both operand sign bits are 1, and C is 1 when either operand sign bit is 1.
- R4: Op codes 1 (subtract) and 2 (compare) apply the add rule to the bit-inverted source and then invert C.
- R5: Op code 3 applies the add rule but places the carry value in bit R and leaves C at 0.
- R6: Op codes 4 to 10 (move, and, or, xor and three shifts) set N to the result sign at the size, set Z when the size-masked result is zero, and leave V and C at 0.
- R7: Op code 11 (signed multiply) forms P = {mulhi_i, res_i}. Z is 1 when P is zero, N is P[63], and V is 1 when `mulhi_i` differs from 32 copies of res_i[31].
- R8: Op code 12 (unsigned multiply) uses the same Z and N rules on P and sets V when `mulhi_i` is nonzero.
- R9: For every class except 13 and 14, bits set in `mask_i`, together with X, take the new flag values. All other bits copy `status_i`. X is therefore always 0.
- R10: When `ext_i` is 1 and the new Z is 1, bit Z is removed from the mask and keeps its old value from `status_i`.
- R11: Op code 13 (bit test) selects bit src_i[4:0] of `dst_i` and writes it to N. Z is set when that bit and all lower bits are zero. X is cleared, V and C are cleared when `ver_i` < 32, and every other bit copies `status_i`. `mask_i` has no effect.
- R12: Op code 14 (flags live) copies `status_i` unchanged to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Evaluate strobe |
| op_i | input | 4 | Operation class code |
| size_i | input | 2 | Operand size code |
| src_i | input | 32 | Recorded source operand |
| dst_i | input | 32 | Recorded destination operand |
| res_i | input | 32 | Recorded result |
| mulhi_i | input | 32 | Upper product word for multiplies |
| ext_i | input | 1 | Extended-arithmetic mode |
| mask_i | input | 32 | Flag update mask |
| ver_i | input | 8 | CPU version number |
| status_i | input | 32 | Previous status word |
| status_o | output | 32 | Updated status word |
| valid_o | output | 1 | Status updated this cycle |

## Verification
Any fault in the sign-bit selection, the source inversion or the merge mask appears on `status_o` one edge after the strobe. The register stage is the only state, so no error can stay hidden past that edge. A sweep crosses every class and every size with operands drawn from all combinations of sign and zero patterns. A wrong size decode, a missing carry flip or a carry that lands in the wrong bit therefore shows up on the first vector that exercises it. Directed cases cover the narrow rules: the mask of zero, the extended-mode zero hold, and the version gate on bit test.

// File: rtl/lflag_pkg.sv
package lflag_pkg;
  localparam int DATA_W = 32;
  localparam int C_POS  = 0;
  localparam int V_POS  = 1;
  localparam int Z_POS  = 2;
  localparam int N_POS  = 3;
  localparam int X_POS  = 4;
  localparam int R_POS  = 8;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_MCP  = 4'd3,
    OP_MOVE = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_LSL  = 4'd8,
    OP_LSR  = 4'd9,
    OP_ASR  = 4'd10,
    OP_MULS = 4'd11,
    OP_MULU = 4'd12,
    OP_BTST = 4'd13,
    OP_LIVE = 4'd14,
    OP_ADDX = 4'd15
  } lf_op_e;

  function automatic logic sign_at(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    return v[7];
      2'd1:    return v[15];
      default: return v[DATA_W-1];
    endcase
  endfunction

  function automatic logic zero_at(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    return v[7:0] == '0;
      2'd1:    return v[15:0] == '0;
      default: return v == '0;
    endcase
  endfunction
endpackage

// File: rtl/lflag_arith.sv
module lflag_arith import lflag_pkg::*; #(
  parameter int STAT_W = 32
) (
  input  logic              sub_i,
  input  logic              mcp_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [STAT_W-1:0] flags_o
);
  logic s, d, r, n, z, v, c;

  always_comb begin
    s = sign_at(sub_i ? ~src_i : src_i, size_i);
    d = sign_at(dst_i, size_i);
    r = sign_at(res_i, size_i);
    n = 1'b0;
    z = 1'b0;
    if (r) begin
      n = 1'b1;
      v = !s && !d;
      c = s && d;
    end else begin
      z = zero_at(res_i, size_i);
      v = s && d;
      c = s || d;
    end
    if (sub_i) c = !c;
    flags_o        = '0;
    flags_o[N_POS] = n;
    flags_o[Z_POS] = z;
    flags_o[V_POS] = v;
    if (mcp_i) flags_o[R_POS] = c;
    else       flags_o[C_POS] = c;
  end
endmodule

// File: rtl/lflag_mul.sv
module lflag_mul import lflag_pkg::*; #(
  parameter int STAT_W    = 32,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic [STAT_W-1:0] flags_o
);
  localparam int PROD_W = 2 * DATA_W;
  logic [PROD_W-1:0] prod;
  logic              ovf;

  assign prod = {hi_i, lo_i};

  generate
    if (IS_SIGNED) begin : g_sgn
      assign ovf = hi_i != {DATA_W{lo_i[DATA_W-1]}};
    end else begin : g_uns
      assign ovf = hi_i != '0;
    end
  endgenerate

  always_comb begin
    flags_o        = '0;
    flags_o[Z_POS] = prod == '0;
    flags_o[N_POS] = prod[PROD_W-1];
    flags_o[V_POS] = ovf;
  end
endmodule

// File: rtl/lflag_logic.sv
module lflag_logic import lflag_pkg::*; #(
  parameter int STAT_W = 32
) (
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [STAT_W-1:0] flags_o
);
  always_comb begin
    flags_o        = '0;
    flags_o[N_POS] = sign_at(res_i, size_i);
    flags_o[Z_POS] = zero_at(res_i, size_i);
  end
endmodule

// File: rtl/lflag_btst.sv
module lflag_btst import lflag_pkg::*; #(
  parameter int STAT_W  = 32,
  parameter int VER_W   = 8,
  parameter int VER_LIM = 32
) (
  input  logic [DATA_W-1:0]         val_i,
  input  logic [$clog2(DATA_W)-1:0] idx_i,
  input  logic [VER_W-1:0]          ver_i,
  input  logic [STAT_W-1:0]         old_i,
  output logic [STAT_W-1:0]         new_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DATA_W - 1);
  logic [DATA_W-1:0] low_mask;

  assign low_mask = {DATA_W{1'b1}} >> (IDX_MAX - idx_i);

  always_comb begin
    new_o        = old_i;
    new_o[X_POS] = 1'b0;
    new_o[N_POS] = val_i[idx_i];
    new_o[Z_POS] = (val_i & low_mask) == '0;
    if (int'(ver_i) < VER_LIM) begin
      new_o[V_POS] = 1'b0;
      new_o[C_POS] = 1'b0;
    end
  end
endmodule

// File: rtl/lflag_merge.sv
module lflag_merge import lflag_pkg::*; #(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] flags_i,
  input  logic [STAT_W-1:0] old_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              ext_i,
  output logic [STAT_W-1:0] new_o
);
  logic [STAT_W-1:0] eff;

  always_comb begin
    eff        = mask_i;
    eff[X_POS] = 1'b1;
    // extended mode: a zero result must not set Z
    if (ext_i && flags_i[Z_POS]) eff[Z_POS] = 1'b0;
    new_o = (old_i & ~eff) | (flags_i & eff);
  end
endmodule

// File: rtl/lazy_flag_unit.sv
module lazy_flag_unit import lflag_pkg::*; #(
  parameter int STAT_W       = 32,
  parameter int VER_W        = 8,
  parameter int BTST_VER_LIM = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] mulhi_i,
  input  logic              ext_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic [VER_W-1:0]  ver_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] status_o,
  output logic              valid_o
);
  localparam int IDX_W = $clog2(DATA_W);

  lf_op_e            op;
  logic              is_sub, is_mcp;
  logic [STAT_W-1:0] arith_flags, logic_flags, sel_flags;
  logic [STAT_W-1:0] mul_flags [2];
  logic [STAT_W-1:0] wb_status, bt_status, next_status;

  assign op     = lf_op_e'(op_i);
  assign is_sub = (op == OP_SUB) || (op == OP_CMP);
  assign is_mcp = op == OP_MCP;

  lflag_arith #(.STAT_W(STAT_W)) u_arith (
    .sub_i(is_sub), .mcp_i(is_mcp), .size_i(size_i),
    .src_i(src_i), .dst_i(dst_i), .res_i(res_i), .flags_o(arith_flags)
  );

  lflag_logic #(.STAT_W(STAT_W)) u_logic (
    .size_i(size_i), .res_i(res_i), .flags_o(logic_flags)
  );

  // index 0: signed, index 1: unsigned
  for (genvar g = 0; g < 2; g++) begin : g_mul
    lflag_mul #(.STAT_W(STAT_W), .IS_SIGNED(g == 0)) u_mul (
      .hi_i(mulhi_i), .lo_i(res_i), .flags_o(mul_flags[g])
    );
  end

  lflag_btst #(.STAT_W(STAT_W), .VER_W(VER_W), .VER_LIM(BTST_VER_LIM)) u_btst (
    .val_i(dst_i), .idx_i(src_i[IDX_W-1:0]), .ver_i(ver_i),
    .old_i(status_i), .new_o(bt_status)
  );

  always_comb begin
    case (op)
      OP_MOVE, OP_AND, OP_OR, OP_XOR,
      OP_LSL, OP_LSR, OP_ASR: sel_flags = logic_flags;
      OP_MULS:                sel_flags = mul_flags[0];
      OP_MULU:                sel_flags = mul_flags[1];
      default:                sel_flags = arith_flags;
    endcase
  end

  lflag_merge #(.STAT_W(STAT_W)) u_merge (
    .flags_i(sel_flags), .old_i(status_i), .mask_i(mask_i),
    .ext_i(ext_i), .new_o(wb_status)
  );

  always_comb begin
    case (op)
      OP_BTST: next_status = bt_status;
      OP_LIVE: next_status = status_i;
      default: next_status = wb_status;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) status_o <= next_status;
    end
  end
endmodule

// File: rtl/lazy_flag_unit_chk.sv
module lazy_flag_unit_chk import lflag_pkg::*; #(
  parameter int STAT_W = 32,
  parameter int VER_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] mulhi_i,
  input logic              ext_i,
  input logic [STAT_W-1:0] mask_i,
  input logic [STAT_W-1:0] status_i,
  input logic [STAT_W-1:0] status_o,
  input logic              valid_o
);
  logic wb_op;
  assign wb_op = (op_i != 4'd13) && (op_i != 4'd14);

  p_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(status_o)));
  p_x_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wb_op) |=> !status_o[X_POS]);
  p_unmasked_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wb_op) |=>
      (((status_o ^ $past(status_i)) & ~($past(mask_i) | (STAT_W'(1) << X_POS))) == '0));
  p_ext_z_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wb_op && ext_i && !status_i[Z_POS]) |=> !status_o[Z_POS]);
  p_btst_n_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd13) |=> (status_o[N_POS] == $past(dst_i[src_i[4:0]])));
  p_mulu_v_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd12 && mask_i[V_POS]) |=> (status_o[V_POS] == ($past(mulhi_i) != '0)));
  p_live_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd14) |=> (status_o == $past(status_i)));
endmodule

bind lazy_flag_unit lazy_flag_unit_chk #(.STAT_W(STAT_W), .VER_W(VER_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .src_i(src_i), .dst_i(dst_i), .mulhi_i(mulhi_i), .ext_i(ext_i),
  .mask_i(mask_i), .status_i(status_i), .status_o(status_o), .valid_o(valid_o)
);

// File: tb/lazy_flag_unit_tb_top.sv
`timescale 1ns/1ps
module lazy_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] src = '0, dst = '0, res = '0, mulhi = '0, mask = '0, st_in = '0;
  logic        ext = 1'b0;
  logic [7:0]  ver = '0;
  logic [31:0] st_out;
  logic        vld_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lazy_flag_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .src_i(src), .dst_i(dst), .res_i(res), .mulhi_i(mulhi), .ext_i(ext),
    .mask_i(mask), .ver_i(ver), .status_i(st_in), .status_o(st_out), .valid_o(vld_out)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0080;
      2: return 32'h0000_7f01;
      3: return 32'h8000_0000;
      4: return 32'hffff_ffff;
      default: return 32'h0001_8000;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [3:0] o, input logic [1:0] sz,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] hi, input logic e, input logic [31:0] m,
      input logic [31:0] old, input logic [7:0] v);
    int top;
    logic [31:0] keep, f, mm, ret;
    logic [63:0] p;
    logic sa, da, ra, cy;
    int cnt;
    int ix;
    top  = (sz == 0) ? 7 : (sz == 1) ? 15 : 31;
    keep = (sz == 0) ? 32'hff : (sz == 1) ? 32'hffff : 32'hffff_ffff;
    f = '0;
    case (o)
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
        f[3] = r[top];
        f[2] = (r & keep) == 0;
      end
      4'd11, 4'd12: begin
        p = {hi, r};
        f[2] = p == 0;
        f[3] = p[63];
        f[1] = (o == 4'd11) ? (p != {{32{r[31]}}, r}) : (hi != 0);
      end
      4'd13: begin
        ix = int'(s[4:0]);
        ret = old;
        ret[4] = 1'b0;
        ret[3] = d[ix];
        ret[2] = (d << (31 - ix)) == 0;
        if (v < 8'd32) begin ret[1] = 1'b0; ret[0] = 1'b0; end
        return ret;
      end
      4'd14: return old;
      default: begin
        sa = (o == 4'd1 || o == 4'd2) ? ~s[top] : s[top];
        da = d[top];
        ra = r[top];
        cnt = int'(sa) + int'(da);
        if (ra) begin
          f[3] = 1'b1; f[1] = (cnt == 0); cy = (cnt == 2);
        end else begin
          f[2] = (r & keep) == 0; f[1] = (cnt == 2); cy = (cnt != 0);
        end
        if (o == 4'd1 || o == 4'd2) cy = ~cy;
        if (o == 4'd3) f[8] = cy; else f[0] = cy;
      end
    endcase
    mm = m | 32'h10;
    if (e && f[2]) mm[2] = 1'b0;
    return (old & ~mm) | (f & mm);
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] r);
    int top;
    top = (sz == 0) ? 7 : (sz == 1) ? 15 : 31;
    case (o)
      4'd1, 4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: return "R6";
      4'd11: return "R7";
      4'd12: return "R8";
      4'd13: return "R11";
      4'd14: return "R12";
      default: return r[top] ? "R2" : "R3";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] s,
      input logic [31:0] d, input logic [31:0] r, input logic [31:0] hi,
      input logic e, input logic [31:0] m, input logic [31:0] old, input logic [7:0] v);
    op = o; size = sz; src = s; dst = d; res = r; mulhi = hi;
    ext = e; mask = m; st_in = old; ver = v; valid = 1'b1;
  endtask

  task automatic single(input string tag, input string what, input logic [3:0] o,
      input logic [1:0] sz, input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] hi, input logic e, input logic [31:0] m, input logic [31:0] old,
      input logic [7:0] v, input logic [31:0] exp);
    @(negedge clk);
    drive(o, sz, s, d, r, hi, e, m, old, v);
    @(negedge clk);
    valid = 1'b0;
    check(tag, what, st_out, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] exp_q, hv, sv;
    string tag_q;
    bit pend;
    pend = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset status", st_out, 32'h0);
    check("R1", "reset valid", {31'b0, vld_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 0; o < 16; o++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 6; a++)
          for (int b = 0; b < 6; b++)
            for (int c = 0; c < 6; c++) begin
              @(negedge clk);
              if (pend) begin
                check(tag_q, "sweep status", st_out, exp_q);
                check("R1", "sweep valid", {31'b0, vld_out}, 32'h1);
              end
              sv = (o == 13) ? $urandom : pick(a);
              case ($urandom % 3)
                0: hv = 32'h0;
                1: hv = 32'hffff_ffff;
                default: hv = $urandom;
              endcase
              drive(4'(o), 2'(sz), sv, pick(b), pick(c), hv, 1'($urandom),
                    $urandom, $urandom, 8'($urandom % 64));
              exp_q = model(op, size, src, dst, res, mulhi, ext, mask, st_in, ver);
              tag_q = tag_of(op, size, res);
              pend = 1;
            end
    @(negedge clk);
    check(tag_q, "sweep status", st_out, exp_q);
    valid = 1'b0;
    exp_q = st_out;
    // R1 hold: new inputs without strobe must not change the output
    op = 4'd14; st_in = ~exp_q;
    @(negedge clk);
    check("R1", "hold status", st_out, exp_q);
    check("R1", "hold valid", {31'b0, vld_out}, 32'h0);

    // R9: empty mask only clears X
    single("R9", "mask zero", 4'd0, 2'd2, 32'h1, 32'h1, 32'h2, 32'h0, 1'b0,
           32'h0, 32'hffff_ffff, 8'd40, 32'hffff_ffef);
    single("R9", "mask full", 4'd4, 2'd2, 32'h0, 32'h0, 32'h8000_0000, 32'h0, 1'b0,
           32'hffff_ffff, 32'h0, 8'd40, 32'h0000_0008);
    // R10: extended mode, zero result keeps old Z
    single("R10", "ext zero keeps Z=0", 4'd0, 2'd1, 32'h0, 32'h0, 32'h0001_0000, 32'h0, 1'b1,
           32'h1f, 32'h0, 8'd40, 32'h0);
    single("R10", "ext zero keeps Z=1", 4'd0, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1,
           32'h1f, 32'h4, 8'd40, 32'h4);
    single("R10", "ext nonzero clears Z", 4'd0, 2'd1, 32'h0, 32'h0, 32'h5, 32'h0, 1'b1,
           32'h1f, 32'h4, 8'd40, 32'h0);
    // R11: version gate on V and C, mask has no effect
    single("R11", "btst old ver", 4'd13, 2'd2, 32'd31, 32'h8000_0000, 32'h0, 32'h0, 1'b0,
           32'h0, 32'h0000_0013, 8'd31, 32'h0000_0008);
    single("R11", "btst new ver", 4'd13, 2'd2, 32'd4, 32'h0000_0001, 32'h0, 32'h0, 1'b0,
           32'hffff_ffff, 32'h0000_0013, 8'd32, 32'h0000_0003);
    single("R11", "btst zero low", 4'd13, 2'd0, 32'd3, 32'hffff_fff0, 32'h0, 32'h0, 1'b0,
           32'h0, 32'h0, 8'd50, 32'h0000_0004);
    // R5: carry goes to bit 8
    single("R5", "mcp carry at R", 4'd3, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 1'b0,
           32'hffff_ffff, 32'h0, 8'd0, 32'h0000_0106);
    // R7: sign extension high word means no overflow
    single("R7", "muls no ovf", 4'd11, 2'd0, 32'h0, 32'h0, 32'hffff_fffe, 32'hffff_ffff, 1'b0,
           32'hf, 32'h0, 8'd0, 32'h0000_0008);
    // R4: subtract equal operands gives Z, no borrow
    single("R4", "sub equal", 4'd1, 2'd2, 32'h5, 32'h5, 32'h0, 32'h0, 1'b0,
           32'hf, 32'h0, 8'd0, 32'h0000_0004);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule